// File: doc/BRIEF.md
# GF(2) Quadratic System Incremental Evaluator Array

This block checks a system of quadratic equations over GF(2) against many candidate assignments at once while an external sequencer walks the free variables in Gray-code order. Every equation owns a constant table of second derivatives. Every equation also has several groups of four instances. The instances of one equation share the quadratic part. They differ only in their starting first derivatives and running result, which fold in a different clamp of the fixed high variables. No instance evaluates a polynomial. On each step it updates one stored first derivative and toggles its running result by that derivative.

The sequencer presents one step per cycle on the step port. A step carries the toggled variable index, a flag that says whether a second toggled index exists, and the table address of the matching second derivative. The step moves through the equations and then through the instance groups as a diagonal wave, one hop per cycle. Each instance ORs its running result into a per-lane accumulator that passes from equation to equation. The accumulated word leaves after the last equation. A zero bit in that word marks a candidate solution for that lane. Before the search starts, a load port fills the tables, the first-derivative memories and the running results.

Top module: `gf2qe_eval_array`

## Requirements
- R1: While reset is high and on the cycle after it, every bit of `sol_valid` and `sol_word` is 0, and every running result is cleared.
- R2: The load port writes one bit per cycle when `load_we` is high. `load_kind` 0 writes second-derivative table bit `load_idx` of equation `load_eq`, where the pair (k, j) with k > j lives at index k(k-1)/2 + j. `load_kind` 1 writes first-derivative entry `load_idx[5:0]` of lane `load_lane` in group `load_grp` of equation `load_eq`. `load_kind` 2 writes that lane's running result.
- R3: On a valid step with `step_has_k2` high, each lane replaces its stored first derivative at index `step_k1` with that value XOR the equation's table bit at `step_addr`, then XORs its running result with the new value.
- R4: On a valid step with `step_has_k2` low, each lane leaves its stored first derivatives unchanged and XORs its running result with the stored entry at `step_k1`.
- R5: For each lane, the accumulated bit after equation j is the OR of the bit after equation j-1 (0 before the first equation) and the lane's new running result in equation j. Bit 4g+l of `sol_word` carries lane l of group g after the last equation, so a 0 bit marks a candidate.
- R6: Each table is stored as 64-bit segments. Address bits [5:0] select the bit within a segment and the upper bits select the segment, so addresses of 64 and above read from the later segments.
- R7: The word for a step sampled on a rising edge is presented with `sol_valid[g]` high on the (NUM_EQ+g)-th rising edge after it, and the steps keep their order.
- R8: A cycle with `step_valid` low changes no stored derivative or running result and produces no output valid pulse, whatever the other step inputs carry.
- R9: After a load with d1[0] = a0, d1[k] = a(k,k-1) XOR a_k and y = constant term, the word for step i equals, per lane, the OR over all equations of that instance's polynomial evaluated at the point i XOR (i >> 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| step_valid | input | 1 | A Gray-code step is present this cycle |
| step_has_k2 | input | 1 | A second toggled index exists for this step |
| step_k1 | input | 6 | Index of the variable toggled by this step |
| step_addr | input | ADDR_W | Second-derivative table address for this step |
| load_we | input | 1 | Load write strobe |
| load_kind | input | 2 | Load target: 0 table, 1 first derivative, 2 running result |
| load_eq | input | EQ_W | Equation selected by the load |
| load_grp | input | GRP_W | Instance group selected by the load |
| load_lane | input | 2 | Lane within the group selected by the load |
| load_idx | input | IDX_W | Table address or first-derivative index |
| load_bit | input | 1 | Bit value written by the load |
| sol_valid | output | NUM_GROUPS | Per-group flag: a solution word is present |
| sol_word | output | 4*NUM_GROUPS | Accumulated solution bits, four per group |

## Verification
A random system with per-instance linear terms and constants runs through several thousand Gray-code steps with random idle cycles that carry junk step fields. This shows whether derivative updates track direct evaluation, whether idle cycles leave state alone, and whether table reads past address 63 pick the right segment. A second, directed system has only per-lane constants in the last equation and is stepped back to back. Here every word must equal a fixed alternating pattern, which separates the load port and the OR chain from the derivative arithmetic. Arrival cycles are compared per group against the expected skew, and a drain after each run shows that no step is lost or duplicated.

// File: rtl/gf2qe_pkg.sv
`timescale 1ns/1ps
package gf2qe_pkg;

    // Fixed grouping and memory shape of one instance group
    localparam int LANES    = 4;
    localparam int D1_DEPTH = 64;
    localparam int K_W      = 6;
    localparam int SEG_BITS = 6;

    typedef enum logic [1:0] {
        LOAD_D2 = 2'd0,
        LOAD_D1 = 2'd1,
        LOAD_Y  = 2'd2
    } load_kind_e;

    // One hop of the step wave travelling across the instance groups
    typedef struct packed {
        logic           vld;
        logic           en2;
        logic [K_W-1:0] k1;
        logic           d2;
    } wave_t;

    function automatic int pair_count(int n);
        return n * (n - 1) / 2;
    endfunction

    function automatic int width_of(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/gf2qe_d2_rom.sv
`timescale 1ns/1ps
module gf2qe_d2_rom
    import gf2qe_pkg::*;
#(
    parameter int DEPTH  = 120,
    parameter int ADDR_W = 7,
    parameter int IDX_W  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_bit,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_bit
);
    localparam int NSEG  = (DEPTH + 63) / 64;
    localparam int SEG_W = width_of(NSEG);

    logic [63:0]      seg_mem [NSEG];
    logic [IDX_W-1:0] rd_ext;
    logic [SEG_W-1:0] rd_seg;
    logic [SEG_W-1:0] wr_seg;

    assign rd_ext = IDX_W'(rd_addr);
    assign rd_seg = SEG_W'(rd_ext >> SEG_BITS);
    assign wr_seg = SEG_W'(wr_idx >> SEG_BITS);

    // Segment picked by the upper address bits, bit picked by the low six
    assign rd_bit = seg_mem[rd_seg][rd_ext[SEG_BITS-1:0]];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            seg_mem[wr_seg][wr_idx[SEG_BITS-1:0]] <= wr_bit;
        end
    end

    // R6: a step that uses the table must address a stored pair
    p_addr_in_range_r6: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (int'(rd_addr) < DEPTH));

endmodule

// File: rtl/gf2qe_lane_group.sv
`timescale 1ns/1ps
module gf2qe_lane_group
    import gf2qe_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  wave_t            wave_in,
    input  logic [LANES-1:0] sol_in,
    output logic [LANES-1:0] sol_out,
    input  logic [LANES-1:0] d1_we,
    input  logic [LANES-1:0] y_we,
    input  logic [K_W-1:0]   load_idx,
    input  logic             load_bit
);
    logic [D1_DEPTH-1:0] d1_mem [LANES];
    logic [LANES-1:0]    y_q;
    logic [LANES-1:0]    d1_rd;
    logic [LANES-1:0]    d1_nx;
    logic [LANES-1:0]    y_nx;

    // All four lanes read and write the same entry on a step
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            d1_rd[l] = d1_mem[l][wave_in.k1];
            d1_nx[l] = d1_rd[l] ^ (wave_in.en2 & wave_in.d2);
            y_nx[l]  = y_q[l] ^ d1_nx[l];
        end
    end

    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (wave_in.vld) begin
                d1_mem[l][wave_in.k1] <= d1_nx[l];
            end else if (d1_we[l]) begin
                d1_mem[l][load_idx] <= load_bit;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            y_q     <= '0;
            sol_out <= '0;
        end else if (wave_in.vld) begin
            y_q     <= y_nx;
            sol_out <= sol_in | y_nx;
        end else begin
            y_q <= (y_q & ~y_we) | ({LANES{load_bit}} & y_we);
        end
    end

    // R8: idle cycles without a load leave the running results alone
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!wave_in.vld && (y_we == '0)) |=> $stable(y_q));

    // R5: a set accumulator bit from the previous equation stays set
    p_or_keep_r5: assert property (@(posedge clk) disable iff (rst)
        wave_in.vld |=> ((sol_out & $past(sol_in)) == $past(sol_in)));

    // R4: without a second index the result toggles by the stored entry
    p_plain_toggle_r4: assert property (@(posedge clk) disable iff (rst)
        (wave_in.vld && !wave_in.en2) |=> ((y_q ^ $past(y_q)) == $past(d1_rd)));

    // R3: with a second index the toggle includes the table bit
    p_d2_fold_r3: assert property (@(posedge clk) disable iff (rst)
        (wave_in.vld && wave_in.en2)
        |=> ((y_q ^ $past(y_q)) == $past(d1_rd ^ {LANES{wave_in.d2}})));

endmodule

// File: rtl/gf2qe_eval_array.sv
`timescale 1ns/1ps
module gf2qe_eval_array
    import gf2qe_pkg::*;
#(
    parameter int  NUM_VARS   = 16,
    parameter int  NUM_EQ     = 3,
    parameter int  NUM_GROUPS = 2,
    localparam int ROM_DEPTH  = pair_count(NUM_VARS),
    localparam int ADDR_W     = width_of(ROM_DEPTH),
    localparam int IDX_W      = (ADDR_W > K_W) ? ADDR_W : K_W,
    localparam int EQ_W       = width_of(NUM_EQ),
    localparam int GRP_W      = width_of(NUM_GROUPS),
    localparam int WORD_W     = NUM_GROUPS * LANES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  step_valid,
    input  logic                  step_has_k2,
    input  logic [K_W-1:0]        step_k1,
    input  logic [ADDR_W-1:0]     step_addr,
    input  logic                  load_we,
    input  logic [1:0]            load_kind,
    input  logic [EQ_W-1:0]       load_eq,
    input  logic [GRP_W-1:0]      load_grp,
    input  logic [1:0]            load_lane,
    input  logic [IDX_W-1:0]      load_idx,
    input  logic                  load_bit,
    output logic [NUM_GROUPS-1:0] sol_valid,
    output logic [WORD_W-1:0]     sol_word
);
    // Equation skew: step fields delayed by one cycle per equation
    logic [NUM_EQ-1:0] eq_vld;
    logic [NUM_EQ-1:0] eq_en2;
    logic [NUM_EQ-1:0] eq_d2;
    logic [K_W-1:0]    eq_k1   [NUM_EQ];
    logic [ADDR_W-1:0] eq_addr [NUM_EQ];

    always_ff @(posedge clk) begin
        if (rst) begin
            eq_vld <= '0;
        end else begin
            eq_vld[0] <= step_valid;
            for (int j = 1; j < NUM_EQ; j++) begin
                eq_vld[j] <= eq_vld[j-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        eq_en2[0]  <= step_has_k2;
        eq_k1[0]   <= step_k1;
        eq_addr[0] <= step_addr;
        for (int j = 1; j < NUM_EQ; j++) begin
            eq_en2[j]  <= eq_en2[j-1];
            eq_k1[j]   <= eq_k1[j-1];
            eq_addr[j] <= eq_addr[j-1];
        end
    end

    wave_t            wave [NUM_EQ][NUM_GROUPS];
    logic [LANES-1:0] sol  [NUM_EQ+1][NUM_GROUPS];
    logic [LANES-1:0] lane_sel;

    assign lane_sel = LANES'(1) << load_lane;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_sol_seed
        assign sol[0][g] = '0;
    end

    for (genvar j = 0; j < NUM_EQ; j++) begin : g_eq
        logic rom_we;
        assign rom_we = load_we && (load_kind == LOAD_D2) && (load_eq == EQ_W'(j));

        gf2qe_d2_rom #(
            .DEPTH  (ROM_DEPTH),
            .ADDR_W (ADDR_W),
            .IDX_W  (IDX_W)
        ) u_rom (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (rom_we),
            .wr_idx  (load_idx),
            .wr_bit  (load_bit),
            .rd_en   (eq_vld[j] && eq_en2[j]),
            .rd_addr (eq_addr[j]),
            .rd_bit  (eq_d2[j])
        );

        assign wave[j][0] = '{vld: eq_vld[j], en2: eq_en2[j], k1: eq_k1[j], d2: eq_d2[j]};

        // Instance skew: the wave hops one group per cycle
        for (genvar g = 1; g < NUM_GROUPS; g++) begin : g_hop
            always_ff @(posedge clk) begin
                if (rst) wave[j][g] <= '0;
                else     wave[j][g] <= wave[j][g-1];
            end
        end

        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
            logic             hit;
            logic [LANES-1:0] d1_we;
            logic [LANES-1:0] y_we;

            assign hit   = load_we && (load_eq == EQ_W'(j)) && (load_grp == GRP_W'(g));
            assign d1_we = (hit && (load_kind == LOAD_D1)) ? lane_sel : '0;
            assign y_we  = (hit && (load_kind == LOAD_Y))  ? lane_sel : '0;

            gf2qe_lane_group u_grp (
                .clk      (clk),
                .rst      (rst),
                .wave_in  (wave[j][g]),
                .sol_in   (sol[j][g]),
                .sol_out  (sol[j+1][g]),
                .d1_we    (d1_we),
                .y_we     (y_we),
                .load_idx (load_idx[K_W-1:0]),
                .load_bit (load_bit)
            );
        end
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_out
        always_ff @(posedge clk) begin
            if (rst) sol_valid[g] <= 1'b0;
            else     sol_valid[g] <= wave[NUM_EQ-1][g].vld;
        end
        assign sol_word[g*LANES +: LANES] = sol[NUM_EQ][g];

        // R7: a later group only reports what its neighbour reported one cycle before
        if (g > 0) begin : g_chk
            p_group_order_r7: assert property (@(posedge clk) disable iff (rst)
                sol_valid[g] |-> $past(sol_valid[g-1]));
        end
    end

endmodule

// File: tb/gf2qe_eval_array_bench.sv
`timescale 1ns/1ps
module gf2qe_eval_array_bench;
    import gf2qe_pkg::*;

    localparam int NV = 16;
    localparam int NE = 3;
    localparam int NG = 2;
    localparam int NI = NG * LANES;
    localparam int RD = pair_count(NV);
    localparam int AW = width_of(RD);
    localparam int IW = (AW > K_W) ? AW : K_W;
    localparam int EW = width_of(NE);
    localparam int GW = width_of(NG);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              step_valid = 1'b0;
    logic              step_has_k2 = 1'b0;
    logic [K_W-1:0]    step_k1 = '0;
    logic [AW-1:0]     step_addr = '0;
    logic              load_we = 1'b0;
    logic [1:0]        load_kind = '0;
    logic [EW-1:0]     load_eq = '0;
    logic [GW-1:0]     load_grp = '0;
    logic [1:0]        load_lane = '0;
    logic [IW-1:0]     load_idx = '0;
    logic              load_bit = 1'b0;
    logic [NG-1:0]     sol_valid;
    logic [NG*LANES-1:0] sol_word;

    gf2qe_eval_array #(.NUM_VARS(NV), .NUM_EQ(NE), .NUM_GROUPS(NG)) u_gf2qe_eval_array (
        .clk(clk), .rst(rst),
        .step_valid(step_valid), .step_has_k2(step_has_k2),
        .step_k1(step_k1), .step_addr(step_addr),
        .load_we(load_we), .load_kind(load_kind), .load_eq(load_eq),
        .load_grp(load_grp), .load_lane(load_lane), .load_idx(load_idx),
        .load_bit(load_bit),
        .sol_valid(sol_valid), .sol_word(sol_word)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int cand_seen = 0;
    int high_addr_steps = 0;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Polynomial coefficients: quadratic part shared per equation
    bit quad [NE][NV][NV];
    bit lin  [NE][NI][NV];
    bit cst  [NE][NI];

    int unsigned exp_w [NG][$];
    int          exp_c [NG][$];

    function automatic bit eval_eq(int e, int inst, int unsigned x);
        bit r = cst[e][inst];
        for (int k = 0; k < NV; k++) begin
            if (x[k]) begin
                r ^= lin[e][inst][k];
                for (int j = 0; j < k; j++) if (x[j]) r ^= quad[e][k][j];
            end
        end
        return r;
    endfunction

    function automatic logic [LANES-1:0] exp_word(int g, int unsigned x);
        logic [LANES-1:0] w = '0;
        for (int l = 0; l < LANES; l++) begin
            bit any = 1'b0;
            for (int e = 0; e < NE; e++) any |= eval_eq(e, g*LANES + l, x);
            w[l] = any;
        end
        return w;
    endfunction

    // Output monitor, sampled away from the clock edge
    always @(negedge clk) begin
        if (!rst) begin
            for (int g = 0; g < NG; g++) begin
                if (sol_valid[g]) begin
                    logic [LANES-1:0] got;
                    logic [LANES-1:0] want;
                    int at;
                    got = sol_word[g*LANES +: LANES];
                    checks++;
                    if (exp_w[g].size() == 0) begin
                        errors++;
                        $display("FAIL R8 group %0d unexpected word got %b expected no output", g, got);
                    end else begin
                        want = LANES'(exp_w[g].pop_front());
                        at = exp_c[g].pop_front();
                        if (got != want) begin
                            errors++;
                            $display("FAIL R9 group %0d word got %b expected %b", g, got, want);
                        end
                        checks++;
                        if (cyc != at) begin
                            errors++;
                            $display("FAIL R7 group %0d arrival got %0d expected %0d", g, cyc, at);
                        end
                        for (int l = 0; l < LANES; l++) if (!got[l]) cand_seen++;
                    end
                end
            end
        end
    end

    task automatic load_one(load_kind_e kind, int e, int g, int l, int idx, bit v);
        @(negedge clk);
        load_we   = 1'b1;
        load_kind = kind;
        load_eq   = EW'(e);
        load_grp  = GW'(g);
        load_lane = 2'(l);
        load_idx  = IW'(idx);
        load_bit  = v;
    endtask

    // R2: table at k(k-1)/2+j, first derivatives per lane, running results
    task automatic load_system();
        for (int e = 0; e < NE; e++) begin
            for (int k = 1; k < NV; k++)
                for (int j = 0; j < k; j++)
                    load_one(LOAD_D2, e, 0, 0, k*(k-1)/2 + j, quad[e][k][j]);
            for (int i = 0; i < NI; i++) begin
                load_one(LOAD_D1, e, i / LANES, i % LANES, 0, lin[e][i][0]);
                for (int k = 1; k < NV; k++)
                    load_one(LOAD_D1, e, i / LANES, i % LANES, k, quad[e][k][k-1] ^ lin[e][i][k]);
                load_one(LOAD_Y, e, i / LANES, i % LANES, 0, cst[e][i]);
            end
        end
        @(negedge clk);
        load_we = 1'b0;
    endtask

    // R3 when a second toggled index exists, R4 otherwise; R6 for addresses above 63
    task automatic do_step(int unsigned i);
        int k1 = -1;
        int k2 = -1;
        int unsigned x;
        for (int b = 0; b < NV; b++) begin
            if (i[b]) begin
                if (k1 < 0) k1 = b;
                else if (k2 < 0) k2 = b;
            end
        end
        @(negedge clk);
        step_valid  = 1'b1;
        step_k1     = K_W'(k1);
        step_has_k2 = (k2 >= 0);
        step_addr   = (k2 >= 0) ? AW'(k2*(k2-1)/2 + k1) : '0;
        if (k2 >= 0 && (k2*(k2-1)/2 + k1) >= 64) high_addr_steps++;
        x = i ^ (i >> 1);
        for (int g = 0; g < NG; g++) begin
            exp_w[g].push_back(int'(exp_word(g, x)));
            exp_c[g].push_back(cyc + 1 + NE + g);
        end
    endtask

    // R8: idle cycle with junk on the other step fields
    task automatic do_idle();
        @(negedge clk);
        step_valid  = 1'b0;
        step_k1     = K_W'($urandom_range(0, 63));
        step_has_k2 = 1'($urandom_range(0, 1));
        step_addr   = AW'($urandom_range(0, RD - 1));
    endtask

    task automatic drain_and_check(string tag);
        repeat (NE + NG + 4) do_idle();
        for (int g = 0; g < NG; g++) begin
            checks++;
            if (exp_w[g].size() != 0) begin
                errors++;
                $display("FAIL R7 %s group %0d pending got %0d expected 0", tag, g, exp_w[g].size());
            end
        end
    endtask

    task automatic check_reset_state();
        checks++;
        if (sol_valid !== '0) begin
            errors++;
            $display("FAIL R1 sol_valid got %b expected 0", sol_valid);
        end
        checks++;
        if (sol_word !== '0) begin
            errors++;
            $display("FAIL R1 sol_word got %h expected 0", sol_word);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        step_valid = 1'b0;
        repeat (3) @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        @(negedge clk);
        check_reset_state();
    endtask

    initial begin
        void'($urandom(32'd4242));
        apply_reset();

        // Phase A: random system, random idle gaps
        for (int e = 0; e < NE; e++) begin
            for (int k = 0; k < NV; k++)
                for (int j = 0; j < NV; j++) quad[e][k][j] = 1'($urandom_range(0, 1));
            for (int i = 0; i < NI; i++) begin
                cst[e][i] = 1'($urandom_range(0, 1));
                for (int k = 0; k < NV; k++) lin[e][i][k] = 1'($urandom_range(0, 1));
            end
        end
        load_system();
        for (int unsigned i = 1; i <= 4500; i++) begin
            if ($urandom_range(0, 3) == 0) do_idle();
            do_step(i);
        end
        drain_and_check("random");
        checks++;
        if (cand_seen == 0) begin
            errors++;
            $display("FAIL R5 candidate bits got %0d expected nonzero", cand_seen);
        end
        checks++;
        if (high_addr_steps == 0) begin
            errors++;
            $display("FAIL R6 steps above address 63 got 0 expected nonzero");
        end

        // Phase B: directed per-lane constants in the last equation, no gaps (R2, R5)
        apply_reset();
        for (int e = 0; e < NE; e++) begin
            for (int k = 0; k < NV; k++)
                for (int j = 0; j < NV; j++) quad[e][k][j] = 1'b0;
            for (int i = 0; i < NI; i++) begin
                cst[e][i] = (e == NE - 1) && ((i % LANES) % 2 == 1);
                for (int k = 0; k < NV; k++) lin[e][i][k] = 1'b0;
            end
        end
        checks++;
        if (exp_word(0, 5) != 4'b1010) begin
            errors++;
            $display("FAIL R2 directed pattern got %b expected 1010", exp_word(0, 5));
        end
        load_system();
        for (int unsigned i = 1; i <= 40; i++) do_step(i);
        drain_and_check("directed");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule